// File: doc/BRIEF.md
# Standby-Isolating General-Purpose I/O Port

This block controls one byte-wide group of general-purpose pins. A small CPU register bus reaches three registers: an output data latch, a direction register and a pull-up enable register. Each pin can be a port input, a port output that drives its latch bit, or an output taken over by a peripheral through a per-pin enable and data bit. The block drives the pad controls: output enable, output value and pull-up enable. It also supplies the synchronized internal input that the core and the peripherals see.

A read of the data register comes in two kinds. A plain read shows the level on each input pin or peripheral-driven pin, and the latch on each port-output pin. A read flagged as read-modify-write always returns the latch, so a bit update does not copy pin levels into the latch. A standby input together with a pin-hold control isolates the port: all drivers are released and the internal input is clamped low. With hold clear, standby leaves the pins exactly as they were. The pull-up is cut while a pin actively drives low.

Top module: `gpio_standby_port`

## Requirements
- R1: A pin with direction bit 1 and no peripheral enable has pad_oe 1 and pad_out equal to its latch bit. A pin with direction 0 and no peripheral enable has pad_oe 0 and pad_out 0.
- R2: A write to address 0 (data) always loads the latch, including bits whose pins are inputs. Those bits do not reach the pad while the direction bit is 0.
- R3: A plain read (rd_rmw 0) at address 0 returns, per bit, the latch bit where direction is 1 and the peripheral enable is 0. Every other bit returns the synchronized pin level.
- R4: A read with rd_rmw 1 at address 0 returns the latch, whatever the direction, peripheral and standby settings.
- R5: A set periph_oe bit gives pad_oe 1 and pad_out equal to the periph_do bit. This overrides the direction bit, and a plain read of that bit returns the synchronized pin level.
- R6: After reset the latch, direction and pull-up registers are 0, pad_oe is 0 and pad_pu is 0.
- R7: pad_pu equals the pull-up register bit, except that it is 0 while the pin has pad_oe 1 and pad_out 0.
- R8: While standby and pin_hold are both 1, pad_oe is 0 on every pin, core_in is 0, and a plain read returns 0 on every bit that R3 routes to the pin.
- R9: While standby is 1 and pin_hold is 0, pad_oe, pad_out and core_in are the same as with standby 0.
- R10: A change on pad_in reaches core_in after exactly two rising clock edges.
- R11: Address 1 reads the direction register, address 2 reads the pull-up register and address 3 reads 0. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up |
| wdata | input | 8 | Write data |
| rd_rmw | input | 1 | Marks the current read as read-modify-write |
| rdata | output | 8 | Combinational read data |
| periph_oe | input | 8 | Per-pin peripheral output enable |
| periph_do | input | 8 | Per-pin peripheral output data |
| standby | input | 1 | Stop or watch mode active |
| pin_hold | input | 1 | Standby pin-state control; 1 isolates pins |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| core_in | output | 8 | Synchronized, isolation-clamped input for core and peripherals |

## Verification
Two pairs of functions can act in the same cycle. The first is a data-register write arriving while a read-modify-write read is pending on the same address. The bench issues the write and then checks that the read, sampled in the following low phase, shows the new latch, while the pad output of input pins stays 0. The second is isolation arriving while peripheral enables and port directions are active. The bench raises standby with pin_hold set over a full set of peripheral and direction patterns and expects every enable and core_in at 0, but latch read-back intact. It then repeats the run with pin_hold clear and expects the outputs to be unchanged.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_PULL = 2'd2,
      REG_NONE = 2'd3
   } gpio_reg_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  gpio_reg_e        addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pull_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         pull_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            REG_DATA: latch_q <= wdata;
            REG_DIR:  dir_q   <= wdata;
            REG_PULL: pull_q  <= wdata;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
   input  logic dir,
   input  logic lat,
   input  logic pull,
   input  logic p_oe,
   input  logic p_do,
   input  logic iso,
   input  logic pin_sync,
   output logic oe,
   output logic out,
   output logic pu,
   output logic core_bit,
   output logic rd_bit
);
   logic drive_req;
   logic drive_val;

   always_comb begin
      drive_req = p_oe | dir;
      drive_val = p_oe ? p_do : lat;
      oe        = drive_req & ~iso;
      out       = oe & drive_val;
      pu        = pull & ~(oe & ~drive_val);
      core_bit  = pin_sync & ~iso;
      rd_bit    = (dir & ~p_oe) ? lat : core_bit;
   end
endmodule

// File: rtl/gpio_standby_port.sv
module gpio_standby_port
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_rmw,
   output logic [WIDTH-1:0] rdata,
   input  logic [WIDTH-1:0] periph_oe,
   input  logic [WIDTH-1:0] periph_do,
   input  logic             standby,
   input  logic             pin_hold,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu,
   output logic [WIDTH-1:0] core_in
);
   localparam int LastBit = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_standby_port: WIDTH must be at least 1");
   end

   gpio_reg_e        reg_sel;
   logic [WIDTH-1:0] latch_q, dir_q, pull_q, pin_sync, rd_norm;
   logic             iso;

   assign reg_sel = gpio_reg_e'(addr);
   assign iso     = standby & pin_hold;

   gpio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_sel), .wdata(wdata),
      .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   for (genvar i = 0; i <= LastBit; i++) begin : g_pin
      gpio_pin_cell u_cell (
         .dir(dir_q[i]), .lat(latch_q[i]), .pull(pull_q[i]),
         .p_oe(periph_oe[i]), .p_do(periph_do[i]), .iso(iso),
         .pin_sync(pin_sync[i]),
         .oe(pad_oe[i]), .out(pad_out[i]), .pu(pad_pu[i]),
         .core_bit(core_in[i]), .rd_bit(rd_norm[i])
      );
   end

   always_comb begin
      case (reg_sel)
         REG_DATA: rdata = rd_rmw ? latch_q : rd_norm;
         REG_DIR:  rdata = dir_q;
         REG_PULL: rdata = pull_q;
         default:  rdata = '0;
      endcase
   end

   AST_WR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == REG_DATA) |=> (latch_q == $past(wdata))); // R2
   AST_RMW_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == REG_DATA && rd_rmw) |-> (rdata == latch_q)); // R4
   AST_ISO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && pin_hold) |-> (pad_oe == '0 && core_in == '0)); // R8
   AST_PU_CUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_oe & ~pad_out) == '0)); // R7
   AST_NONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == REG_NONE) |=> $stable({latch_q, dir_q, pull_q})); // R11
   AST_DRIVE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (!iso) |-> (pad_oe == (dir_q | periph_oe))); // R1
endmodule

// File: tb/gpio_standby_port_tb.sv
module gpio_standby_port_tb;
   logic clk = 0;
   logic rst_n = 0;
   logic wr_en = 0;
   logic [1:0] addr = 0;
   logic [7:0] wdata = 0;
   logic rd_rmw = 0;
   logic [7:0] rdata;
   logic [7:0] periph_oe = 0, periph_do = 0, pad_in = 0;
   logic standby = 0, pin_hold = 0;
   logic [7:0] pad_oe, pad_out, pad_pu, core_in;
   int checks = 0, failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_standby_port u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_rmw(rd_rmw), .rdata(rdata), .periph_oe(periph_oe), .periph_do(periph_do),
      .standby(standby), .pin_hold(pin_hold), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .core_in(core_in)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] v);
      addr = a; rd_rmw = rmw; #1; v = rdata; rd_rmw = 0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      #2;
   endtask

   initial begin
      logic [7:0] v, lat, dir, pu, pin, poe, pdo, oe_ref, out_ref;
      repeat (2) @(negedge clk);
      // R6 reset state
      chk("R6 pad_oe", pad_oe, 8'h00);
      chk("R6 pad_pu", pad_pu, 8'h00);
      rst_n = 1;
      rd(2'd0, 1, v); chk("R6 latch", v, 8'h00);
      rd(2'd1, 0, v); chk("R6 dir", v, 8'h00);
      rd(2'd2, 0, v); chk("R6 pull", v, 8'h00);

      // R1 R3 R4 R7 sweep over port configurations
      for (int k = 0; k < 256; k++) begin
         dir = k[7:0]; lat = dir ^ 8'h5A; pu = ~dir ^ 8'h33; pin = dir * 8'd3 + 8'd1;
         wr(2'd1, dir); wr(2'd0, lat); wr(2'd2, pu);
         pad_in = pin;
         settle();
         chk("R1 oe", pad_oe, dir);
         chk("R1 out", pad_out, dir & lat);
         rd(2'd0, 0, v); chk("R3 plain read", v, (dir & lat) | (~dir & pin));
         rd(2'd0, 1, v); chk("R4 rmw read", v, lat);
         chk("R7 pull-up", pad_pu, pu & ~(dir & ~lat));
         rd(2'd1, 0, v); chk("R11 dir read", v, dir);
         rd(2'd2, 0, v); chk("R11 pull read", v, pu);
         rd(2'd3, 0, v); chk("R11 none read", v, 8'h00);
      end

      // R2 write into input pins; write coinciding with rmw read
      wr(2'd1, 8'h00);
      @(negedge clk); addr = 0; wdata = 8'hC3; wr_en = 1; rd_rmw = 1;
      @(negedge clk); wr_en = 0; #1;
      chk("R2 rmw after write", rdata, 8'hC3);
      rd_rmw = 0;
      chk("R2 input pins not driven oe", pad_oe, 8'h00);
      chk("R2 input pins not driven out", pad_out, 8'h00);

      // R11 write to address 3 ignored
      wr(2'd1, 8'h0F); wr(2'd2, 8'hF0); wr(2'd3, 8'hAA);
      rd(2'd0, 1, v); chk("R11 latch kept", v, 8'hC3);
      rd(2'd1, 0, v); chk("R11 dir kept", v, 8'h0F);
      rd(2'd2, 0, v); chk("R11 pull kept", v, 8'hF0);

      // R5 R8 R9 peripheral override and standby over patterns
      for (int k = 0; k < 64; k++) begin
         poe = k[7:0] * 8'd37; pdo = k[7:0] * 8'd91 + 8'd5; dir = k[7:0] ^ 8'hA5;
         lat = ~pdo; pin = k[7:0] * 8'd13;
         wr(2'd1, dir); wr(2'd0, lat);
         periph_oe = poe; periph_do = pdo; pad_in = pin;
         standby = 0; pin_hold = 0;
         settle();
         oe_ref = poe | dir;
         out_ref = (poe & pdo) | (~poe & dir & lat);
         chk("R5 oe", pad_oe, oe_ref);
         chk("R5 out", pad_out, out_ref);
         rd(2'd0, 0, v); chk("R5 plain read", v, (dir & ~poe & lat) | (~(dir & ~poe) & pin));
         standby = 1; pin_hold = 0; #1;
         chk("R9 oe kept", pad_oe, oe_ref);
         chk("R9 out kept", pad_out, out_ref);
         chk("R9 core kept", core_in, pin);
         pin_hold = 1; #1;
         chk("R8 oe off", pad_oe, 8'h00);
         chk("R8 core low", core_in, 8'h00);
         rd(2'd0, 0, v); chk("R8 plain read", v, dir & ~poe & lat);
         rd(2'd0, 1, v); chk("R4 rmw in standby", v, lat);
         standby = 0; pin_hold = 0;
      end
      periph_oe = 0;

      // R10 synchronizer latency
      pad_in = 8'h00; settle();
      @(negedge clk); pad_in = 8'h96;
      @(negedge clk); #1; chk("R10 after one edge", core_in, 8'h00);
      @(negedge clk); #1; chk("R10 after two edges", core_in, 8'h96);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule